// File: doc/BRIEF.md
# Addressable LED Strip Serializer

This block turns a frame of pixel colours into the two-wire clock-and-data stream understood by addressable RGB LED strips with 5-bit colour channels. A one-cycle start request sets it running. It then sends three things in turn:

- a zero-data lead-in of 32 clock pulses;
- one 16-bit cell per pixel;
- a closing burst of zero-data clock pulses, one per pixel.

While this runs, a busy flag stays high.

Pixel colours come from storage outside the block through a simple read port. The serializer places a pixel number on `pix_idx_o`. It expects the matching 15-bit colour word on `pix_rgb_i` from the following cycle onward. The next pixel is requested while the current cell is still shifting out. The clock rate is set at build time: each high phase and each low phase of `sclk_o` lasts `CLK_DIV+1` system clocks. Data changes only while `sclk_o` is low, so the strip can capture it on the rising edge.

The control state machine has five states:

- `ST_IDLE`: waits for `start_i`.
- `ST_LEAD`: the zero preamble.
- `ST_CELL`: pixel cells.
- `ST_TAIL`: the closing burst.
- `ST_DONE`: a one-cycle wind-down.

Its transitions are:

- idle to lead on start;
- lead to cell after the 32nd slot;
- cell to cell at each pixel boundary;
- cell to tail after the last bit of the last pixel;
- tail to done after the `NPIX`-th burst slot;
- done to idle unconditionally.

Top module: `led_strip_ser`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `sclk_o` and `sdo_o` are both low.
- R2: A start request seen while idle sets `busy_o` in the next cycle. `busy_o` then stays high for exactly 2*(CLK_DIV+1)*(32+17*NPIX)+1 cycles.
- R3: Each high phase of `sclk_o` lasts CLK_DIV+1 cycles. Each low phase before a rising edge, counted from the cycle `busy_o` rose or from the previous falling edge, also lasts CLK_DIV+1 cycles.
- R4: A frame opens with 32 rising edges of `sclk_o` at which `sdo_o` is 0.
- R5: Every pixel cell opens with one bit of value 1, clocked like a data bit.
- R6: After the opening bit, a cell carries blue, then red, then green, 5 bits each, most significant bit first. The read word is laid out as blue in bits 14:10, red in bits 9:5 and green in bits 4:0.
- R7: After the last cell, `NPIX` more rising edges follow with `sdo_o` at 0, and a frame holds 32+17*NPIX rising edges in total.
- R8: `sdo_o` stays unchanged for every cycle in which `sclk_o` is high.
- R9: A start request while `busy_o` is high has no effect: the frame length is unchanged and no second frame follows.
- R10: `pix_idx_o` stays within 0..NPIX-1. The word for pixel k is taken from `pix_rgb_i` no earlier than one full cycle after `pix_idx_o` shows k, and before cell k begins.
- R11: `busy_o` falls exactly one cycle after the final falling edge of `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to send a frame |
| busy_o | output | 1 | High while a frame is in progress |
| pix_idx_o | output | IDX_W | Pixel number requested from colour storage |
| pix_rgb_i | input | 3*CH_W | Colour word for the requested pixel, {blue, red, green} |
| sclk_o | output | 1 | Strip clock |
| sdo_o | output | 1 | Strip data |

## Verification
`busy_o` is due one cycle after the start request is sampled. It then lasts a fixed, arithmetically known number of cycles, and it drops one cycle after the last falling edge of `sclk_o`. Every rising edge of `sclk_o` falls exactly 2*(CLK_DIV+1) cycles after the previous one.

The bench drives inputs and samples outputs on the falling system clock edge. It records `sdo_o` at the first sample in which `sclk_o` is seen high, and compares the recorded stream bit by bit against a stream built from the colour words. The pixel store in the bench answers one cycle after the index, as the read port prescribes. Phase lengths, the busy window and the busy-to-clock spacing are counted in samples and compared with the formulas in R2, R3 and R11.

// File: rtl/ledser_pkg.sv
package ledser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CELL,
        ST_TAIL,
        ST_DONE
    } ser_state_t;

    localparam int LEAD_SLOTS = 32;

endpackage

// File: rtl/ledser_phase.sv
module ledser_phase #(
    parameter int CLK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_hi,
    output logic slot_end
);
    localparam int TW = (CLK_DIV > 0) ? $clog2(CLK_DIV + 1) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(CLK_DIV);

    logic [TW-1:0] tcnt_q;
    logic          hi_q;
    logic          phase_end;

    assign phase_end = (tcnt_q == T_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tcnt_q <= '0;
            hi_q   <= 1'b0;
        end else if (phase_end) begin
            tcnt_q <= '0;
            hi_q   <= ~hi_q;
        end else begin
            tcnt_q <= tcnt_q + 1'b1;
        end
    end

    assign phase_hi = hi_q;
    assign slot_end = run & hi_q & phase_end;

endmodule

// File: rtl/ledser_shift.sv
module ledser_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_word,
    output logic         msb
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_word;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[W-1];

endmodule

// File: rtl/led_strip_ser.sv
module led_strip_ser
    import ledser_pkg::*;
#(
    parameter int NPIX    = 50,
    parameter int CLK_DIV = 3,
    parameter int CH_W    = 5,
    parameter int IDX_W   = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic [IDX_W-1:0]  pix_idx_o,
    input  logic [3*CH_W-1:0] pix_rgb_i,
    output logic              sclk_o,
    output logic              sdo_o
);
    localparam int CELL_BITS = 3 * CH_W + 1;
    localparam int MAX_A     = (LEAD_SLOTS > CELL_BITS) ? LEAD_SLOTS : CELL_BITS;
    localparam int MAX_SLOTS = (MAX_A > NPIX) ? MAX_A : NPIX;
    localparam int BW        = $clog2(MAX_SLOTS);
    localparam logic [BW-1:0]    LEAD_LAST = BW'(LEAD_SLOTS - 1);
    localparam logic [BW-1:0]    CELL_LAST = BW'(CELL_BITS - 1);
    localparam logic [BW-1:0]    TAIL_LAST = BW'(NPIX - 1);
    localparam logic [IDX_W-1:0] PIX_LAST  = IDX_W'(NPIX - 1);

    ser_state_t       state_q, state_d;
    logic [BW-1:0]    slot_q, slot_d;
    logic [IDX_W-1:0] pix_q, pix_d;
    logic [IDX_W-1:0] fetch_q, fetch_d;

    logic run, phase_hi, slot_end;
    logic sh_clear, sh_load, sh_shift, sh_msb;

    assign run = (state_q == ST_LEAD) || (state_q == ST_CELL) || (state_q == ST_TAIL);

    ledser_phase #(.CLK_DIV(CLK_DIV)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .phase_hi (phase_hi),
        .slot_end (slot_end)
    );

    ledser_shift #(.W(CELL_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .load      (sh_load),
        .shift     (sh_shift),
        .load_word ({1'b1, pix_rgb_i}),
        .msb       (sh_msb)
    );

    // next-state and datapath control
    always_comb begin
        state_d  = state_q;
        slot_d   = slot_q;
        pix_d    = pix_q;
        fetch_d  = fetch_q;
        sh_clear = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_LEAD;
                    slot_d   = '0;
                    pix_d    = '0;
                    fetch_d  = '0;
                    sh_clear = 1'b1;
                end
            end
            ST_LEAD: begin
                if (slot_end) begin
                    if (slot_q == LEAD_LAST) begin
                        state_d = ST_CELL;
                        slot_d  = '0;
                        sh_load = 1'b1;
                        fetch_d = (fetch_q == PIX_LAST) ? fetch_q : fetch_q + 1'b1;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
            end
            ST_CELL: begin
                if (slot_end) begin
                    if (slot_q == CELL_LAST) begin
                        slot_d = '0;
                        if (pix_q == PIX_LAST) begin
                            state_d  = ST_TAIL;
                            sh_clear = 1'b1;
                        end else begin
                            pix_d   = pix_q + 1'b1;
                            sh_load = 1'b1;
                            fetch_d = (fetch_q == PIX_LAST) ? fetch_q : fetch_q + 1'b1;
                        end
                    end else begin
                        slot_d   = slot_q + 1'b1;
                        sh_shift = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (slot_end) begin
                    if (slot_q == TAIL_LAST) begin
                        state_d = ST_DONE;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            pix_q   <= '0;
            fetch_q <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            pix_q   <= pix_d;
            fetch_q <= fetch_d;
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        sclk_o    = phase_hi;
        sdo_o     = (state_q == ST_CELL) && sh_msb;
        pix_idx_o = fetch_q;
    end

endmodule

// File: rtl/ledser_chk.sv
module ledser_chk #(
    parameter int NPIX    = 50,
    parameter int CLK_DIV = 3,
    parameter int IDX_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic [IDX_W-1:0] pix_idx_o,
    input logic             sclk_o,
    input logic             sdo_o
);
    logic [15:0] hi_run, lo_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= sclk_o ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : 16'd0;
            lo_run <= (busy_o && !sclk_o) ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1) : 16'd0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && !sdo_o));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_run == 16'(CLK_DIV + 1)));

    p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (lo_run == 16'(CLK_DIV + 1)));

    p_data_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdo_o));

    p_idx_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(pix_idx_o) < NPIX));

    p_busy_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(sclk_o, 2) && !$past(sclk_o)));

endmodule

bind led_strip_ser ledser_chk #(
    .NPIX    (NPIX),
    .CLK_DIV (CLK_DIV),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .pix_idx_o (pix_idx_o),
    .sclk_o    (sclk_o),
    .sdo_o     (sdo_o)
);

// File: tb/led_strip_ser_test.sv
`timescale 1ns/1ps
module led_strip_ser_test;
    localparam int NPIX  = 3;
    localparam int DIV   = 1;
    localparam int CH_W  = 5;
    localparam int IDX_W = 2;
    localparam int FB    = 32 + 17 * NPIX;
    localparam int BUSY_LEN = 2 * (DIV + 1) * FB + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic busy_o, sclk_o, sdo_o;
    logic [IDX_W-1:0] pix_idx_o;
    logic [3*CH_W-1:0] pix_rgb_i;
    logic [3*CH_W-1:0] mem [NPIX];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit got_bits [FB];

    always #2 clk = ~clk;

    always_ff @(posedge clk) pix_rgb_i <= mem[pix_idx_o];

    led_strip_ser #(.NPIX(NPIX), .CLK_DIV(DIV), .CH_W(CH_W), .IDX_W(IDX_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .busy_o    (busy_o),
        .pix_idx_o (pix_idx_o),
        .pix_rgb_i (pix_rgb_i),
        .sclk_o    (sclk_o),
        .sdo_o     (sdo_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int i);
        int c, k, j;
        if (i < 32) return 1'b0;          // R4 lead-in
        if (i >= 32 + 17 * NPIX) return 1'b0;
        if (i >= 32 + 16 * NPIX) return 1'b0; // R7 closing burst
        c = i - 32;
        k = c / 16;
        j = c % 16;
        if (j == 0) return 1'b1;          // R5 marker
        return mem[k][15 - j];            // R6 blue, red, green, msb first
    endfunction

    task automatic run_frame(input bit extra_start);
        int cyc, nbits, lorun, hirun, last_fall;
        int width_bad, hold_bad, idx_bad;
        int lead_bad, mark_bad, chan_bad, tail_bad;
        bit prev, cur;
        cyc = 0; nbits = 0; lorun = 0; hirun = 0; last_fall = -1;
        width_bad = 0; hold_bad = 0; idx_bad = 0;
        lead_bad = 0; mark_bad = 0; chan_bad = 0; tail_bad = 0;
        prev = 1'b0; cur = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after start", int'(busy_o), 1);
        while (busy_o && cyc < 4000) begin
            start_i = (extra_start && (cyc == 50 || cyc == 200)); // R9 requests while busy
            if (sclk_o) begin
                if (!prev) begin
                    if (nbits < FB) got_bits[nbits] = sdo_o;
                    nbits++;
                    cur = sdo_o;
                    if (lorun != DIV + 1) width_bad++;
                    lorun = 0;
                    hirun = 0;
                end
                hirun++;
                if (sdo_o != cur) hold_bad++;
            end else begin
                if (prev) begin
                    if (hirun != DIV + 1) width_bad++;
                    last_fall = cyc;
                end
                lorun++;
            end
            if (int'(pix_idx_o) >= NPIX) idx_bad++;
            if (!sclk_o && sdo_o == 1'b0 && 1'b0) idx_bad++;
            prev = sclk_o;
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R2 busy length", cyc, BUSY_LEN);
        check("R11 busy fall after last clock fall", last_fall, cyc - 1);
        check("R7 rising edge count", nbits, FB);
        check("R3 phase widths", width_bad, 0);
        check("R8 data held while clock high", hold_bad, 0);
        check("R10 index range", idx_bad, 0);
        for (int i = 0; i < FB && i < nbits; i++) begin
            if (got_bits[i] != exp_bit(i)) begin
                if (i < 32) lead_bad++;
                else if (i >= 32 + 16 * NPIX) tail_bad++;
                else if (((i - 32) % 16) == 0) mark_bad++;
                else chan_bad++;
            end
        end
        check("R4 lead-in bits", lead_bad, 0);
        check("R5 marker bits", mark_bad, 0);
        check("R6 channel bits (R10 fetch)", chan_bad, 0);
        check("R7 closing burst bits", tail_bad, 0);
        check("R1 outputs idle after frame", int'(sclk_o) + int'(sdo_o), 0);
        if (extra_start) begin
            for (int t = 0; t < 8; t++) begin
                check("R9 no second frame", int'(busy_o), 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NPIX; p++) mem[p] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset busy", int'(busy_o), 0);
        check("R1 reset sclk", int'(sclk_o), 0);
        check("R1 reset sdo", int'(sdo_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // walking single one over every bit of every pixel
        for (int p = 0; p < NPIX; p++) begin
            for (int b = 0; b < 3 * CH_W; b++) begin
                for (int q = 0; q < NPIX; q++) mem[q] = '0;
                mem[p] = 15'(1) << b;
                run_frame(1'b0);
            end
        end
        // all zero, all one, distinct mixed words
        for (int q = 0; q < NPIX; q++) mem[q] = '0;
        run_frame(1'b0);
        for (int q = 0; q < NPIX; q++) mem[q] = '1;
        run_frame(1'b0);
        mem[0] = 15'h7C00; mem[1] = 15'h03E0; mem[2] = 15'h001F;
        run_frame(1'b0);
        mem[0] = 15'h5A5A; mem[1] = 15'h2C71; mem[2] = 15'h1234;
        run_frame(1'b1);   // R9: repeated start requests mid-frame
        run_frame(1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule